// File: doc/BRIEF.md
# Double-Buffered Serial DAC Register Front End

This block is the digital front end of a 16-bit converter with a serial input. A host frames each word with an active-low chip select, presents the bits most significant first on a data line, and marks each bit with a rising edge of a serial clock. A frame that carries exactly the code width in bits is committed to an input register when chip select is released. A frame with any other bit count is dropped, and the input register keeps its previous word.

A second register holds the code that drives the converter core. It is filled from the input register by a level-sensitive, active-low load input. An active-low clear input forces this output register to midscale (0x8000 at the default width) and overrides the load for as long as it is held low. A clear never touches the input register, so a load made after the clear is released applies the last word received.

All five host pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and the edges of interest are detected in the system clock domain. A hardware reset sets both registers to midscale.

Top module: `dac_dbuf_front`

## Requirements
- R1: After hardware reset, `dac_code` is 0x8000 and the input register holds 0x8000, so a load issued before any frame gives 0x8000.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts in one bit from `sdi`, most significant bit first. When `cs_n` rises after exactly 16 such edges, the 16-bit word is committed to the input register.
- R3: A frame with fewer or more than 16 rising `sclk` edges, including a frame with none, is discarded. The input register keeps its previous word.
- R4: Rising `sclk` edges while `cs_n` is high shift nothing and do not count toward the next frame.
- R5: While `load_n` is low and `clr_n` is high, `dac_code` follows the input register. A falling `load_n` is visible on `dac_code` three system clock cycles after the input changes, and not after two cycles.
- R6: While `load_n` and `clr_n` are both high, `dac_code` holds its value, even when new frames are committed.
- R7: A falling `clr_n` sets `dac_code` to 0x8000 three system clock cycles after the input changes.
- R8: While `clr_n` is low, `load_n` has no effect and `dac_code` stays at 0x8000.
- R9: A clear leaves the input register unchanged. A load after `clr_n` returns high applies the last committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low, level-sensitive transfer from the input register to the output register |
| clr_n | input | 1 | Active-low clear to midscale; overrides the load while low |
| dac_code | output | 16 | Code presented to the converter core |

## Verification
The input register cannot be seen directly. A wrong word or a wrong bit count therefore shows up only when the next load moves it to `dac_code`, three cycles after `load_n` falls. The bench pairs each frame with a load, so a bad commit or a missed discard appears in the same step. A fault in the load or clear priority, or in the synchronizer depth, changes `dac_code` one cycle early or late, or leaves it wrong while the control level is held. The bench samples exactly at the second and third cycle after each control change to catch both kinds of error.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  localparam int unsigned CODE_W_DEF = 16;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2
  } dac_act_e;

  // Priority of the output register: clear over load over hold.
  function automatic dac_act_e pick_action(input logic load_lvl_n, input logic clr_lvl_n);
    if (!clr_lvl_n) return ACT_CLEAR;
    if (!load_lvl_n) return ACT_LOAD;
    return ACT_HOLD;
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned STAGES  = dac_fe_pkg::SYNC_STAGES_DEF,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/edge_det.sv
module edge_det #(
  parameter logic RISING  = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = lvl & ~prev_q;
    end else begin : g_fall
      assign pulse = ~lvl & prev_q;
    end
  endgenerate

  // A detected edge lasts a single cycle.
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int unsigned W = dac_fe_pkg::CODE_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_lvl_n,
  input  logic         cs_rise,
  input  logic         sclk_rise,
  input  logic         sdi_lvl,
  output logic [W-1:0] in_word,
  output logic         commit_evt
);

  localparam int unsigned CNT_W   = $clog2(W + 2);
  localparam int unsigned CNT_SAT = W + 1;
  localparam logic [W-1:0] MID    = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] shift_msb_first(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  logic [W-1:0]     shreg_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic             shift_evt;

  assign shift_evt  = !cs_lvl_n && sclk_rise;
  assign commit_evt = cs_rise && (bit_cnt_q == CNT_W'(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
    end else if (cs_lvl_n) begin
      bit_cnt_q <= '0;
    end else if (sclk_rise && bit_cnt_q != CNT_W'(CNT_SAT)) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg_q <= '0;
    else if (shift_evt) shreg_q <= shift_msb_first(shreg_q, sdi_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          in_word <= MID;
    else if (commit_evt) in_word <= shreg_q;
  end

  // R3
  bad_count_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt_q != CNT_W'(W)) |=> $stable(in_word));

  // R4
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl_n |=> (bit_cnt_q == '0));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= CNT_W'(CNT_SAT));

endmodule

// File: rtl/dac_reg.sv
module dac_reg #(
  parameter int unsigned W = dac_fe_pkg::CODE_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_lvl_n,
  input  logic         clr_lvl_n,
  input  logic         clr_fall,
  input  logic [W-1:0] in_word,
  output logic [W-1:0] dac_q
);
  import dac_fe_pkg::*;

  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  dac_act_e act;

  assign act = pick_action(load_lvl_n, clr_lvl_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= MID;
    end else begin
      case (act)
        ACT_CLEAR: dac_q <= MID;
        ACT_LOAD:  dac_q <= in_word;
        default:   dac_q <= dac_q;
      endcase
    end
  end

  // R7
  clear_edge_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (dac_q == MID));

  // R8
  clear_held_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_lvl_n |=> (dac_q == MID));

  // R5
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_lvl_n && clr_lvl_n) |=> (dac_q == $past(in_word)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lvl_n && clr_lvl_n) |=> $stable(dac_q));

endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front #(
  parameter int unsigned CODE_W      = dac_fe_pkg::CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = dac_fe_pkg::SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              load_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] dac_code
);

  logic cs_s, sclk_s, sdi_s, load_s, clr_s;
  logic cs_rise, sclk_rise, clr_fall;
  logic commit_evt;
  logic [CODE_W-1:0] in_word;

  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n), .sync_out(cs_s));
  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .async_in(sclk), .sync_out(sclk_s));
  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .async_in(sdi), .sync_out(sdi_s));
  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
    .clk(clk), .rst_n(rst_n), .async_in(load_n), .sync_out(load_s));
  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clr (
    .clk(clk), .rst_n(rst_n), .async_in(clr_n), .sync_out(clr_s));

  edge_det #(.RISING(1'b1), .RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl(cs_s), .pulse(cs_rise));
  edge_det #(.RISING(1'b1), .RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .pulse(sclk_rise));
  edge_det #(.RISING(1'b0), .RST_VAL(1'b1)) u_clr_edge (
    .clk(clk), .rst_n(rst_n), .lvl(clr_s), .pulse(clr_fall));

  frame_rx #(.W(CODE_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_lvl_n(cs_s), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sdi_lvl(sdi_s),
    .in_word(in_word), .commit_evt(commit_evt));

  dac_reg #(.W(CODE_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .load_lvl_n(load_s), .clr_lvl_n(clr_s),
    .clr_fall(clr_fall), .in_word(in_word), .dac_q(dac_code));

  // R9
  clear_keeps_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !commit_evt) |=> $stable(in_word));

endmodule

// File: tb/dac_dbuf_front_test.sv
module dac_dbuf_front_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [15:0] MID = 16'h8000;
  localparam int NVEC = 8;
  // {bit count, word}; only a count of 16 commits the word.
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd16, 16'hA5C3}, {8'd16, 16'h0001}, {8'd15, 16'h1234}, {8'd17, 16'hFFFF},
    {8'd16, 16'hFFFF}, {8'd0,  16'h5555}, {8'd16, 16'h0000}, {8'd1,  16'h8000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic [W-1:0] dac_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_front uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .load_n(load_n), .clr_n(clr_n), .dac_code(dac_code));

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dac_code=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sclk_pulse();
    wait_n(4); sclk = 1'b1; wait_n(4); sclk = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] word, input int nbits);
    cs_n = 1'b0;
    wait_n(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = word[15 - (i % 16)];
      sclk_pulse();
    end
    wait_n(4);
    cs_n = 1'b1;
    wait_n(8);
  endtask

  task automatic load_pulse();
    load_n = 1'b0; wait_n(6); load_n = 1'b1; wait_n(6);
  endtask

  initial begin
    logic [15:0] model;
    model = MID;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1: reset state of both registers
    check("R1 reset output", dac_code, MID);
    load_pulse();
    check("R1 reset input register", dac_code, MID);

    // R2 / R3: vector table
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][15:0], int'(VEC[v][23:16]));
      if (VEC[v][23:16] == 8'd16) model = VEC[v][15:0];
      load_pulse();
      check((VEC[v][23:16] == 8'd16) ? "R2 frame commit" : "R3 frame discard", dac_code, model);
    end

    // R4: stray serial clocks outside a frame
    for (int i = 0; i < 5; i++) begin sdi = 1'b1; sclk_pulse(); end
    wait_n(4);
    send_frame(16'h3C5A, 16);
    load_pulse();
    check("R4 idle clocks ignored", dac_code, 16'h3C5A);
    model = 16'h3C5A;

    // R6: hold with load and clear high
    send_frame(16'h1111, 16);
    check("R6 hold after commit", dac_code, 16'h3C5A);
    model = 16'h1111;

    // R5: latency of load
    load_n = 1'b0;
    wait_n(2);
    check("R5 load not yet after two cycles", dac_code, 16'h3C5A);
    wait_n(1);
    check("R5 load after three cycles", dac_code, 16'h1111);
    // R5: follow while load held low
    send_frame(16'hBEEF, 16);
    check("R5 follow while load low", dac_code, 16'hBEEF);
    model = 16'hBEEF;

    // R7: clear latency with load still low
    clr_n = 1'b0;
    wait_n(2);
    check("R7 clear not yet after two cycles", dac_code, 16'hBEEF);
    wait_n(1);
    check("R7 clear after three cycles", dac_code, MID);
    // R8: load held and pulsed while clear low
    wait_n(6);
    check("R8 load low ignored during clear", dac_code, MID);
    load_n = 1'b1; wait_n(4);
    load_pulse();
    check("R8 load pulse ignored during clear", dac_code, MID);
    // R9: release clear with load high, then load the last word
    clr_n = 1'b1; wait_n(6);
    check("R9 midscale kept after clear release", dac_code, MID);
    load_pulse();
    check("R9 last word after clear", dac_code, model);

    // R1: reset in mid operation restores midscale in both registers
    rst_n = 1'b0; wait_n(2);
    check("R1 reset during operation", dac_code, MID);
    rst_n = 1'b1; wait_n(2);
    load_pulse();
    check("R1 input register reset", dac_code, MID);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule